// File: doc/BRIEF.md
# Disk DMA Transmit FIFO Controller

This block carries outbound data from host memory to a disk drive while the controller runs a DMA write to the drive. A system DMA engine pushes 32-bit longwords into a transmit FIFO. The FIFO counts its fill in 16-bit halfwords and drains one halfword at a time toward the drive. When the fill drops under a programmable alarm level, the block asks the system DMA for another packet. The usual setting is the FIFO depth minus twice the packet size, both in halfwords.

On the drive side, the block answers the drive's DMA request with an acknowledge. The drive then takes one halfword per strobe. The bus cycle timing for the two DMA flavours is reduced to this one-halfword-per-strobe handshake. The flow stops when the FIFO runs dry, when the drive withdraws its request, or when software clears its pending bit. It starts again by itself once none of those holds. A clear input empties the FIFO before a new transfer is set up. The drive's interrupt line is registered into an end-of-transfer flag.

Top module: `dma_tx_fifo_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `drv_ack`, `refill_req`, `fill_level`, `overflow`, `out_valid` and `xfer_done` are all zero.
- R2: An accepted longword write adds two halfwords to `fill_level`. Halfwords leave in write order, and within a longword bits [15:0] come out before bits [31:16].
- R3: A write is accepted only when `fifo_en` is 1 and `fill_level` is at most DEPTH_HW-2. A rejected write with `fifo_en` = 1 leaves the contents unchanged and sets the sticky `overflow` flag. A write with `fifo_en` = 0 is dropped and does not set the flag.
- R4: `refill_req` is registered. After each clock edge it equals `fifo_en` AND `refill_en` AND (`fill_level` < `alarm_lvl`), evaluated before that edge.
- R5: `drv_ack` rises on the edge that follows the moment `drv_req`, `fifo_en`, `dma_pend` and `dir_tx` (1 means host to drive) are all high. It falls on the first edge after any one of them goes low.
- R6: `out_valid` is high only while `drv_ack` is high and the FIFO is not empty. A `drv_strobe` while `out_valid` is low removes nothing.
- R7: Once every pause cause clears, halfwords flow again without any other input changing.
- R8: A one-cycle `fifo_clr` pulse empties the FIFO and clears `overflow`.
- R9: `xfer_done` follows `drv_irq` one clock later.
- R10: `bus_mode` is the registered `mode_udma` select: 0 means multiword DMA and 1 means ultra DMA.
- R11: An accepted write and a halfword taken on the same edge raise `fill_level` by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO enable |
| refill_en | input | 1 | Allows refill requests to the system DMA |
| dma_pend | input | 1 | Software DMA-pending bit |
| dir_tx | input | 1 | Direction, 1 = host to drive |
| mode_udma | input | 1 | Mode select, 0 = multiword, 1 = ultra |
| fifo_clr | input | 1 | Empties FIFO, clears overflow |
| alarm_lvl | input | 7 | Refill alarm level in halfwords |
| wr_valid | input | 1 | Longword write strobe from system DMA |
| wr_data | input | 32 | Longword write data |
| refill_req | output | 1 | Refill request to system DMA |
| overflow | output | 1 | Sticky dropped-write flag |
| fill_level | output | 7 | FIFO fill in halfwords |
| drv_req | input | 1 | Drive DMA request |
| drv_ack | output | 1 | DMA acknowledge to drive |
| drv_strobe | input | 1 | Drive takes one halfword |
| out_valid | output | 1 | Halfword available on out_data |
| out_data | output | 16 | Halfword toward the drive |
| drv_irq | input | 1 | Drive interrupt request |
| xfer_done | output | 1 | End-of-transfer flag |
| bus_mode | output | 1 | Registered mode select |

## Verification
A longword write from the system DMA and a halfword drain by the drive can land on the same clock edge, and the fill count must then add both effects. The bench provokes this by raising `wr_valid` and `drv_strobe` together for one cycle while the acknowledge is up and the FIFO is part full. It expects the fill to rise by exactly one. It then drains everything through its queue, which confirms that the new longword landed behind the older data in the right halfword order.

// File: rtl/tx_pkg.sv
`timescale 1ns/1ps
package tx_pkg;
  typedef enum logic {BUS_MWDMA = 1'b0, BUS_UDMA = 1'b1} bus_mode_e;
  localparam int LW_W = 32;
  localparam int HW_W = 16;
endpackage

// File: rtl/txf_buffer.sv
`timescale 1ns/1ps
module txf_buffer #(
  parameter int DEPTH_HW = 64,
  parameter int CW = $clog2(DEPTH_HW + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    wr_valid,
  input  logic [tx_pkg::LW_W-1:0] wr_data,
  input  logic                    rd_take,
  output logic [CW-1:0]           fill,
  output logic                    empty,
  output logic                    ovf,
  output logic [tx_pkg::HW_W-1:0] rd_data
);
  localparam int LW_DEPTH = DEPTH_HW / 2;
  localparam int AW = $clog2(LW_DEPTH);

  logic [tx_pkg::LW_W-1:0] mem [LW_DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW:0]   rd_ptr;
  logic          accept;
  logic [tx_pkg::LW_W-1:0] head_lw;

  assign accept  = en && wr_valid && (fill <= CW'(DEPTH_HW - 2));
  assign empty   = (fill == '0);
  assign head_lw = mem[rd_ptr[AW:1]];
  assign rd_data = rd_ptr[0] ? head_lw[31:16] : head_lw[15:0];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      ovf    <= 1'b0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      if (rd_take) rd_ptr <= rd_ptr + 1'b1;
      fill <= fill + (accept ? CW'(2) : CW'(0)) - (rd_take ? CW'(1) : CW'(0));
      if (en && wr_valid && !accept) ovf <= 1'b1;
    end
  end

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH_HW));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_take |-> !empty);
  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (accept && !rd_take) |=> (fill == $past(fill) + CW'(2)));
  // R11
  both_step_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (accept && rd_take) |=> (fill == $past(fill) + CW'(1)));
endmodule

// File: rtl/txf_refill.sv
`timescale 1ns/1ps
module txf_refill #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ren,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] alarm,
  output logic          req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= en && ren && (fill < alarm);
  end

  // R4
  refill_gate_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(en && ren));
endmodule

// File: rtl/txf_drive_if.sv
`timescale 1ns/1ps
module txf_drive_if (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pend,
  input  logic dir_tx,
  input  logic mode_sel,
  input  logic drv_req,
  input  logic drv_strobe,
  input  logic empty,
  output logic ack,
  output logic valid,
  output logic take,
  output logic mode_q
);
  assign valid = ack && !empty;
  assign take  = drv_strobe && valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack    <= 1'b0;
      mode_q <= tx_pkg::BUS_MWDMA;
    end else begin
      ack    <= en && pend && dir_tx && drv_req;
      mode_q <= mode_sel;
    end
  end

  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!drv_req || !pend) |=> !ack);
  // R5
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_req && pend && en && dir_tx) |=> ack);
endmodule

// File: rtl/dma_tx_fifo_ctrl.sv
`timescale 1ns/1ps
module dma_tx_fifo_ctrl #(
  parameter int DEPTH_HW = 64,
  parameter int CW = $clog2(DEPTH_HW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          refill_en,
  input  logic          dma_pend,
  input  logic          dir_tx,
  input  logic          mode_udma,
  input  logic          fifo_clr,
  input  logic [CW-1:0] alarm_lvl,
  input  logic          wr_valid,
  input  logic [31:0]   wr_data,
  output logic          refill_req,
  output logic          overflow,
  output logic [CW-1:0] fill_level,
  input  logic          drv_req,
  output logic          drv_ack,
  input  logic          drv_strobe,
  output logic          out_valid,
  output logic [15:0]   out_data,
  input  logic          drv_irq,
  output logic          xfer_done,
  output logic          bus_mode
);
  logic empty;
  logic take;

  txf_buffer #(.DEPTH_HW(DEPTH_HW), .CW(CW)) u_buf (
    .clk(clk), .rst(rst), .clr(fifo_clr), .en(fifo_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_take(take),
    .fill(fill_level), .empty(empty), .ovf(overflow), .rd_data(out_data)
  );

  txf_refill #(.CW(CW)) u_refill (
    .clk(clk), .rst(rst), .en(fifo_en), .ren(refill_en),
    .fill(fill_level), .alarm(alarm_lvl), .req(refill_req)
  );

  txf_drive_if u_drv (
    .clk(clk), .rst(rst), .en(fifo_en), .pend(dma_pend), .dir_tx(dir_tx),
    .mode_sel(mode_udma), .drv_req(drv_req), .drv_strobe(drv_strobe),
    .empty(empty), .ack(drv_ack), .valid(out_valid), .take(take),
    .mode_q(bus_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) xfer_done <= 1'b0;
    else     xfer_done <= drv_irq;
  end

  // R9
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    drv_irq |=> xfer_done);
  // R8
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (fill_level == '0 && !overflow));
endmodule

// File: tb/test_dma_tx_fifo_ctrl.sv
`timescale 1ns/1ps
module test_dma_tx_fifo_ctrl;
  localparam int DEPTH = 64;
  logic clk = 0;
  logic rst = 1;
  logic fifo_en = 0, refill_en = 0, dma_pend = 0, dir_tx = 0, mode_udma = 0, fifo_clr = 0;
  logic [6:0] alarm_lvl = '0;
  logic wr_valid = 0;
  logic [31:0] wr_data = '0;
  logic refill_req, overflow, drv_ack, out_valid, xfer_done, bus_mode;
  logic [6:0] fill_level;
  logic drv_req = 0, drv_strobe = 0, drv_irq = 0;
  logic [15:0] out_data;

  int checks = 0, errors = 0, exp_fill = 0, seq = 0;
  logic [15:0] q [$];

  always #2 clk = ~clk;

  dma_tx_fifo_ctrl i_dma_tx_fifo_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // driver: push one longword, model acceptance from R3
  task automatic push_lw();
    logic [15:0] lo, hi;
    lo = 16'(16'h1000 + 2 * seq);
    hi = 16'(16'h1000 + 2 * seq + 1);
    seq++;
    wr_data = {hi, lo};
    wr_valid = 1;
    if (fifo_en && exp_fill <= DEPTH - 2) begin
      q.push_back(lo); q.push_back(hi); exp_fill += 2;
    end
    step();
    wr_valid = 0;
  endtask

  task automatic drain(input int n);
    drv_strobe = 1;
    repeat (n) @(posedge clk);
    #1;
    drv_strobe = 0;
  endtask

  // monitor: compare every taken halfword (R2 ordering)
  always @(negedge clk) begin
    if (!rst && out_valid && drv_strobe) begin
      if (q.size() == 0) chk(0, "R2 unexpected halfword", out_data, 0);
      else begin
        logic [15:0] e;
        e = q.pop_front();
        chk(out_data == e, "R2 halfword order", out_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    @(negedge clk);
    chk(drv_ack == 0 && refill_req == 0 && fill_level == 0 && overflow == 0 && xfer_done == 0 && out_valid == 0,
        "R1 reset state", {drv_ack, refill_req, overflow, xfer_done}, 0);
    step();
    fifo_en = 1; refill_en = 1; alarm_lvl = 7'd32; dir_tx = 1; mode_udma = 1;
    step();
    @(negedge clk);
    chk(refill_req == 1, "R4 request below alarm", refill_req, 1);
    chk(bus_mode == 1, "R10 ultra mode", bus_mode, 1);
    step();
    for (int i = 0; i < 16; i++) push_lw();
    @(negedge clk);
    chk(fill_level == 32, "R2 fill after 16 writes", fill_level, 32);
    step();
    @(negedge clk);
    chk(refill_req == 0, "R4 request off at alarm", refill_req, 0);
    step();
    for (int i = 0; i < 16; i++) push_lw();
    push_lw();
    @(negedge clk);
    chk(fill_level == 64, "R3 full fill", fill_level, 64);
    chk(overflow == 1, "R3 sticky overflow", overflow, 1);
    step();
    dma_pend = 1; drv_req = 1;
    step();
    @(negedge clk);
    chk(drv_ack == 1, "R5 ack rises", drv_ack, 1);
    step();
    drain(10); exp_fill -= 10;
    @(negedge clk);
    chk(fill_level == 7'(exp_fill), "R2 fill after drain", fill_level, exp_fill);
    step();
    drv_req = 0;
    step();
    @(negedge clk);
    chk(drv_ack == 0, "R5 ack drops on request low", drv_ack, 0);
    step();
    drain(3);
    @(negedge clk);
    chk(fill_level == 7'(exp_fill), "R6 strobe without ack ignored", fill_level, exp_fill);
    step();
    drv_req = 1;
    step();
    @(negedge clk);
    chk(drv_ack == 1 && out_valid == 1, "R7 resumes after request", {drv_ack, out_valid}, 3);
    step();
    drain(4); exp_fill -= 4;
    dma_pend = 0;
    step();
    @(negedge clk);
    chk(drv_ack == 0, "R5 ack drops on pending clear", drv_ack, 0);
    step();
    dma_pend = 1;
    step();
    @(negedge clk);
    chk(drv_ack == 1, "R7 resumes after pending", drv_ack, 1);
    step();
    dir_tx = 0;
    step();
    @(negedge clk);
    chk(drv_ack == 0, "R5 no ack with receive direction", drv_ack, 0);
    step();
    dir_tx = 1;
    step();
    step();
    // R11 simultaneous write and drain
    drv_strobe = 1;
    push_lw();
    drv_strobe = 0;
    exp_fill -= 1;
    @(negedge clk);
    chk(fill_level == 7'(exp_fill), "R11 write plus take", fill_level, exp_fill);
    step();
    drain(exp_fill); exp_fill = 0;
    @(negedge clk);
    chk(fill_level == 0 && out_valid == 0 && drv_ack == 1, "R6 empty pauses", {fill_level, out_valid}, 0);
    chk(q.size() == 0, "R2 all halfwords delivered", q.size(), 0);
    step();
    drain(3);
    @(negedge clk);
    chk(fill_level == 0, "R6 strobe on empty ignored", fill_level, 0);
    step();
    refill_en = 0;
    step(); step();
    @(negedge clk);
    chk(refill_req == 0, "R4 refill disabled", refill_req, 0);
    step();
    push_lw();
    @(negedge clk);
    chk(out_valid == 1, "R7 resumes after refill", out_valid, 1);
    step();
    drain(2); exp_fill -= 2;
    chk(q.size() == 0, "R2 lower half first", q.size(), 0);
    push_lw(); push_lw();
    fifo_clr = 1;
    step();
    fifo_clr = 0;
    q.delete(); exp_fill = 0;
    @(negedge clk);
    chk(fill_level == 0 && overflow == 0, "R8 clear empties", {overflow, fill_level}, 0);
    step();
    fifo_en = 0;
    push_lw();
    @(negedge clk);
    chk(fill_level == 0 && overflow == 0, "R3 disabled write dropped", {overflow, fill_level}, 0);
    step();
    drv_irq = 1;
    step();
    @(negedge clk);
    chk(xfer_done == 1, "R9 done follows irq", xfer_done, 1);
    step();
    drv_irq = 0; mode_udma = 0;
    step();
    @(negedge clk);
    chk(xfer_done == 0, "R9 done clears", xfer_done, 0);
    chk(bus_mode == 0, "R10 multiword mode", bus_mode, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule